// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Output Port

This block is one 16-pin slice of a memory-mapped general-purpose output port. It holds an output latch that drives the pins. Software can read and write that latch directly. A second, write-only command register changes chosen latch bits in a single bus write, so no read-modify-write sequence is needed. In that register the lower half sets bits and the upper half clears bits. A zero bit does nothing, and when both the set bit and the clear bit for a pin are asserted, the set wins.

The register port is a simple synchronous one: word address, write enable, byte strobes, write data and read data. Read data is registered and appears one cycle after the address is presented. The pin inputs pass through a two-flop synchronizer and can be read through a read-only input register. The port handles one access per cycle, in the order the accesses arrive.

Register word addresses: 0 is the input register (read-only), 1 is the output latch (read/write), and 2 is the set/clear command (write-only, reads as zero).

Top module: `gpio_atomic_out`

## Requirements
- R1: After reset the output latch and `pin_out` are 0x0000 and `rd_data` is 0.
- R2: A write to address 1 replaces each output byte whose strobe is set (strobe 0 covers bits 7:0 and strobe 1 covers bits 15:8) with the write data. Byte lanes whose strobe is clear keep their value. The new value appears on `pin_out` in the next cycle.
- R3: A write to address 2 with bit i (0..15) at 1 forces output bit i to 1 in the next cycle.
- R4: A write to address 2 with bit i+16 at 1 forces output bit i to 0 in the next cycle.
- R5: Command bits written as 0 leave the matching output bits unchanged.
- R6: When a command write asserts both bit i and bit i+16, output bit i becomes 1.
- R7: Strobes 0 to 3 gate command bytes 7:0, 15:8, 23:16 and 31:24. A halfword write to only the set half or only the clear half therefore acts alone.
- R8: Reading address 2 returns 0. Reading address 1 returns the output latch in bits 15:0 with zeros above. The command has a one-shot effect, so a later direct write still replaces the latch.
- R9: Reading address 0 returns the pin inputs as they were two clock edges earlier, passed through the synchronizer. Writes to address 0 have no effect.
- R10: Writes to addresses outside 0..2, and writes with no strobe set, leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| addr | input | 2 | register word address |
| wr_en | input | 1 | write strobe |
| be | input | 4 | byte lane enables |
| wr_data | input | 32 | write data |
| rd_data | output | 32 | registered read data |
| pin_in | input | 16 | raw pin levels |
| pin_out | output | 16 | output latch driving pins |

## Verification
On every cycle, assertions check the update rule for the set/clear command: set bits end high, cleared bits without a set end low, and all other bits hold. They also check that a cycle without a qualifying write leaves the latch unchanged, and that read-back of the command address is zero. The bench's scenarios show the byte-lane gating and halfword independence, the two-cycle latency of the input synchronizer, and that a one-shot command does not lock later direct writes. The bench checks these against a behavioural model compared on each clock.

// File: rtl/gpio_atomic_out.sv
module gpio_atomic_out #(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [3:0]    be,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out
);
  localparam logic [1:0] A_IN  = 2'd0;
  localparam logic [1:0] A_OUT = 2'd1;
  localparam logic [1:0] A_CMD = 2'd2;

  logic [W-1:0] odr, sync1, sync2;
  logic [31:0]  mask, wd;
  logic [W-1:0] set_v, clr_v, dir_v, odr_nx;
  logic         wr_out, wr_cmd;

  assign mask   = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  assign wd     = wr_data & mask;
  assign wr_out = wr_en && addr == A_OUT;
  assign wr_cmd = wr_en && addr == A_CMD;
  assign set_v  = wd[W-1:0];
  assign clr_v  = wd[2*W-1:W];
  assign dir_v  = (odr & ~mask[W-1:0]) | wd[W-1:0];

  always_comb begin
    odr_nx = odr;
    if (wr_out)      odr_nx = dir_v;
    else if (wr_cmd) odr_nx = (odr & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odr   <= '0;
      sync1 <= '0;
      sync2 <= '0;
      rd_data <= '0;
    end else begin
      odr   <= odr_nx;
      sync1 <= pin_in;
      sync2 <= sync1;
      case (addr)
        A_IN:    rd_data <= 32'(sync2);
        A_OUT:   rd_data <= 32'(odr);
        default: rd_data <= '0;
      endcase
    end
  end

  assign pin_out = odr;

  // R3 R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> ((pin_out & $past(set_v)) == $past(set_v)));
  // R4
  clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> ((pin_out & ($past(clr_v) & ~$past(set_v))) == '0));
  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (((pin_out ^ $past(pin_out)) & ~($past(set_v) | $past(clr_v))) == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_out || wr_cmd) |=> $stable(pin_out));
  // R8
  cmd_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CMD) |=> (rd_data == '0));
endmodule

// File: tb/gpio_atomic_out_bench.sv
module gpio_atomic_out_bench;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [3:0] be = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [15:0] pin_in = 0, pin_out;
  int tests = 0, fails = 0;
  logic [15:0] model = 0;
  logic [15:0] pin_hist[$];

  gpio_atomic_out u_gpio_atomic_out (.clk, .rst_n, .addr, .wr_en, .be,
    .wr_data, .rd_data, .pin_in, .pin_out);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // per-clock model comparison
  always @(posedge clk) begin
    if (!rst_n) model <= 0;
    else if (wr_en) begin
      logic [31:0] m, d;
      m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      d = wr_data & m;
      if (addr == 1) model <= (model & ~m[15:0]) | d[15:0];
      else if (addr == 2) begin
        for (int i = 0; i < 16; i++)
          if (d[i]) model[i] <= 1'b1;
          else if (d[i+16]) model[i] <= 1'b0;
      end
    end
  end
  always @(negedge clk) if (rst_n) chk("R2-model", pin_out, model);

  task automatic wr(logic [1:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk); addr = a; be = b; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0; be = 0;
  endtask
  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; wr_en = 0;
    @(negedge clk); v = rd_data;
  endtask

  initial begin
    #(CLK_P*150000); fails++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R1 out", pin_out, 16'h0000);
    chk("R1 rd", rd_data, 0);
    rst_n = 1;
    wr(1, 4'b0011, 32'h0000_A5C3); chk("R2 full", pin_out, 16'hA5C3);
    wr(1, 4'b0001, 32'h0000_FF11); chk("R2 lane0", pin_out, 16'hA511);
    wr(1, 4'b0010, 32'h0000_3C00); chk("R2 lane1", pin_out, 16'h3C11);
    wr(2, 4'b1111, 32'h0000_8002); chk("R3 set", pin_out, 16'hBC13);
    wr(2, 4'b1111, 32'h0011_0000); chk("R4 clr", pin_out, 16'hBC02);
    wr(2, 4'b1111, 32'h0000_0000); chk("R5 zero", pin_out, 16'hBC02);
    wr(2, 4'b1111, 32'h0041_0041); chk("R6 setwins", pin_out, 16'hBC43);
    wr(2, 4'b1100, 32'h8000_00FF); chk("R7 clr half", pin_out, 16'h3C43);
    wr(2, 4'b0011, 32'hFFFF_0100); chk("R7 set half", pin_out, 16'h3D43);
    wr(2, 4'b0100, 32'hFFFF_FFFF); chk("R7 byte2", pin_out, 16'h3D00);
    rd(2, v); chk("R8 cmd rd", v, 0);
    rd(1, v); chk("R8 out rd", v, 32'h0000_3D00);
    wr(1, 4'b0011, 32'h0000_0001); chk("R8 no lock", pin_out, 16'h0001);
    wr(3, 4'b1111, 32'hFFFF_FFFF); chk("R10 bad addr", pin_out, 16'h0001);
    wr(1, 4'b0000, 32'hFFFF_FFFF); chk("R10 no be", pin_out, 16'h0001);
    wr(0, 4'b1111, 32'hFFFF_FFFF); chk("R9 in wr", pin_out, 16'h0001);
    @(negedge clk); pin_in = 16'h1234; addr = 0;
    @(negedge clk); chk("R9 lat1", rd_data, 0);
    @(negedge clk); chk("R9 lat2", rd_data, 0);
    @(negedge clk); chk("R9 lat3", rd_data, 32'h1234);
    for (int k = 0; k < 40; k++)
      wr(k[0] ? 2'd2 : 2'd1, 4'(k * 7), {16'(k * 4093), 16'(k * 257 + 3)});
    chk("R2 final", pin_out, model);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule